// File: doc/BRIEF.md
# Dual-Clock Match Timer with APB Register Port

This block is a 32-bit up-counter with a compare register, a programmable prescaler and three match behaviours: stop, reload to zero, or keep running. Software reaches it through a 32-bit APB3 slave port clocked by `pclk`. The counter itself lives on `tclk`, which may be unrelated to the bus clock. Every register write, and every count read, crosses between the two domains through a toggle request and acknowledge handshake. PREADY stays low while that handshake is in flight, so a 32-bit count is always read or written as one coherent word.

A match sets a sticky pending flag in the timer domain. That flag is brought into the bus domain through a synchroniser. Each domain has its own interrupt output: the pending flag gated by the interrupt-enable bit. Control and status pins are plain levels. The only transfer path is APB, and it applies back-pressure through wait states: any access that needs the timer domain holds PREADY low until the acknowledge returns, and the master must hold its request stable for that whole time.

Top module: `tmr_apb_dualclk`

## Requirements
- R1: After reset every register reads zero: control, compare, prescaler, count and status. Both interrupt outputs are low.
- R2: Address map: control at 0x00, compare at 0x04, prescaler at 0x08, count at 0x0C, status at 0x10. In control, bit0 is run enable, bits 2:1 are the mode (00 stop-on-match, 01 reload-on-match, 10 free-run) and bit3 is interrupt enable. Compare, prescaler, mode and interrupt enable read back as written.
- R3: With prescaler value N, the counter advances once every N+1 `tclk` cycles.
- R4: In mode 00, once the count equals the compare value, the run enable clears by itself. Control bit0 then reads 0 and the count holds at the compare value.
- R5: In mode 01, the step that would make the count equal the compare value loads zero instead, and counting continues. A match repeats every compare × (N+1) `tclk` cycles.
- R6: In mode 10, the counter runs past the compare value without stopping or reloading. The match still sets the pending flag.
- R7: A match sets status bit0. Writing 1 to status bit0 clears it. Writing 0 leaves it set.
- R8: `irq_bus` and `irq_tmr` are high exactly when the pending flag is set and control bit3 is 1. With bit3 at 0 both stay low while the flag remains set.
- R9: A write to count loads that value. A read of count returns a coherent 32-bit snapshot. A count access always inserts at least one wait state (PREADY low).
- R10: Clearing run enable freezes the count. Setting it again resumes counting from the frozen value.
- R11: PSLVERR is 0 on every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-domain reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready; low while a crossing is pending |
| pslverr | output | 1 | APB error, always 0 |
| tclk | input | 1 | Timer clock |
| trstn | input | 1 | Timer-domain reset, active low |
| irq_bus | output | 1 | Match interrupt, synchronous to pclk |
| irq_tmr | output | 1 | Match interrupt, synchronous to tclk |

## Verification
The embedded assertions watch the following on every cycle:
- the self-stop after a match in mode 00;
- the zero reload after a match in mode 01;
- the prescaler counter never passing its limit;
- the request toggle staying still while a crossing is pending;
- the forced wait state on a count access.

Some behaviours only the bench scenarios can show, because they span both clocks:
- the exact match period in `tclk` cycles for two prescaler values;
- read-back values after stop, pause and resume;
- the write-1-to-clear rule;
- the masking of both interrupt outputs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_STOP   = 2'b00,
    MODE_RELOAD = 2'b01,
    MODE_FREE   = 2'b10
  } tmr_mode_e;

  typedef struct packed {
    logic        irq_en;
    tmr_mode_e   mode;
    logic [31:0] cmp;
  } tmr_cfg_t;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_CMP  = 8'h04;
  localparam logic [7:0] OFS_PSC  = 8'h08;
  localparam logic [7:0] OFS_CNT  = 8'h0C;
  localparam logic [7:0] OFS_STAT = 8'h10;
endpackage

// File: rtl/tmr_bit_sync.sv
module tmr_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = (STAGES < 2) ? 1 : STAGES - 1;
  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LAST-1:0], d};
  end

  assign q = chain[LAST];
endmodule

// File: rtl/tmr_apb_regs.sv
module tmr_apb_regs
  import tmr_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int PSC_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              req_tgl_o,
  output tmr_cfg_t          cfg_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic              en_o,
  output logic [31:0]       cnt_val_o,
  output logic              ld_ctrl_o,
  output logic              ld_cnt_o,
  output logic              clr_o,
  input  logic              ack_tgl_i,
  input  logic [31:0]       hold_i,
  input  logic              run_i,
  input  logic              flag_i,
  output logic              irq_o
);
  logic ack_s, run_s, flag_s;
  logic busy, req_q;
  logic en_q, ie_q;
  logic [1:0] mode_q;
  logic [31:0] cmp_q, cnt_val_q;
  logic [PSC_W-1:0] psc_q;
  logic ld_ctrl_q, ld_cnt_q, clr_q;

  tmr_bit_sync #(.STAGES(SYNC_STAGES)) u_ack  (.clk(pclk), .rst_n(presetn), .d(ack_tgl_i), .q(ack_s));
  tmr_bit_sync #(.STAGES(SYNC_STAGES)) u_run  (.clk(pclk), .rst_n(presetn), .d(run_i),     .q(run_s));
  tmr_bit_sync #(.STAGES(SYNC_STAGES)) u_flag (.clk(pclk), .rst_n(presetn), .d(flag_i),    .q(flag_s));

  logic hit_ctrl, hit_cmp, hit_psc, hit_cnt, hit_stat;
  logic access, needs_xing, done, start;

  assign hit_ctrl = (paddr == ADDR_W'(OFS_CTRL));
  assign hit_cmp  = (paddr == ADDR_W'(OFS_CMP));
  assign hit_psc  = (paddr == ADDR_W'(OFS_PSC));
  assign hit_cnt  = (paddr == ADDR_W'(OFS_CNT));
  assign hit_stat = (paddr == ADDR_W'(OFS_STAT));

  assign access     = psel && penable;
  assign needs_xing = pwrite ? (hit_ctrl || hit_cmp || hit_psc || hit_cnt || hit_stat) : hit_cnt;
  assign done       = busy && (req_q == ack_s);
  assign start      = access && needs_xing && !busy;
  assign pready     = access && (!needs_xing || done);
  assign pslverr    = 1'b0;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      busy      <= 1'b0;
      req_q     <= 1'b0;
      en_q      <= 1'b0;
      ie_q      <= 1'b0;
      mode_q    <= 2'b00;
      cmp_q     <= '0;
      psc_q     <= '0;
      cnt_val_q <= '0;
      ld_ctrl_q <= 1'b0;
      ld_cnt_q  <= 1'b0;
      clr_q     <= 1'b0;
    end else if (start) begin
      busy      <= 1'b1;
      req_q     <= ~req_q;
      ld_ctrl_q <= pwrite && hit_ctrl;
      ld_cnt_q  <= pwrite && hit_cnt;
      clr_q     <= pwrite && hit_stat && pwdata[0];
      if (pwrite && hit_ctrl) begin
        en_q   <= pwdata[0];
        mode_q <= pwdata[2:1];
        ie_q   <= pwdata[3];
      end
      if (pwrite && hit_cmp) cmp_q     <= pwdata;
      if (pwrite && hit_psc) psc_q     <= pwdata[PSC_W-1:0];
      if (pwrite && hit_cnt) cnt_val_q <= pwdata;
    end else if (done) begin
      busy <= 1'b0;
    end
  end

  always_comb begin
    prdata = '0;
    if (hit_ctrl)      prdata = {28'd0, ie_q, mode_q, run_s};
    else if (hit_cmp)  prdata = cmp_q;
    else if (hit_psc)  prdata = 32'(psc_q);
    else if (hit_cnt)  prdata = hold_i;
    else if (hit_stat) prdata = {31'd0, flag_s};
  end

  assign req_tgl_o   = req_q;
  assign cfg_o       = '{irq_en: ie_q, mode: tmr_mode_e'(mode_q), cmp: cmp_q};
  assign psc_o       = psc_q;
  assign en_o        = en_q;
  assign cnt_val_o   = cnt_val_q;
  assign ld_ctrl_o   = ld_ctrl_q;
  assign ld_cnt_o    = ld_cnt_q;
  assign clr_o       = clr_q;
  assign irq_o       = flag_s && ie_q;

  // R9
  req_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (busy && !done) |=> $stable(req_q));
  // R9
  cnt_wait_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (access && hit_cnt && !busy) |-> !pready);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int PSC_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_tgl_i,
  input  tmr_cfg_t         cfg_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             en_i,
  input  logic [31:0]      cnt_val_i,
  input  logic             ld_ctrl_i,
  input  logic             ld_cnt_i,
  input  logic             clr_i,
  output logic             ack_tgl_o,
  output logic [31:0]      hold_o,
  output logic             run_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic req_s, req_d, strobe;
  tmr_bit_sync #(.STAGES(SYNC_STAGES)) u_req (.clk(clk), .rst_n(rst_n), .d(req_tgl_i), .q(req_s));
  assign strobe = req_s ^ req_d;

  tmr_cfg_t         cfg_q;
  logic [PSC_W-1:0] psc_q, psc_cnt;
  logic [31:0]      cnt, nxt, hold_q;
  logic             run, flag, ack_q;
  logic             tick, match;

  assign tick  = run && (psc_cnt == psc_q);
  assign nxt   = cnt + 32'd1;
  assign match = tick && (nxt == cfg_q.cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d   <= 1'b0;
      cfg_q   <= '0;
      psc_q   <= '0;
      psc_cnt <= '0;
      cnt     <= '0;
      hold_q  <= '0;
      run     <= 1'b0;
      flag    <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      req_d <= req_s;
      if (run) psc_cnt <= tick ? '0 : psc_cnt + 1'b1;
      if (tick) begin
        if (match && cfg_q.mode == MODE_RELOAD) cnt <= '0;
        else                                    cnt <= nxt;
        if (match && cfg_q.mode == MODE_STOP)   run <= 1'b0;
      end
      if (match)              flag <= 1'b1;
      else if (strobe && clr_i) flag <= 1'b0;
      if (strobe) begin
        cfg_q  <= cfg_i;
        hold_q <= cnt;
        ack_q  <= req_s;
        if (psc_i != psc_q) begin
          psc_q   <= psc_i;
          psc_cnt <= '0;
        end
        if (ld_ctrl_i) run <= en_i;
        if (ld_cnt_i) begin
          cnt     <= cnt_val_i;
          psc_cnt <= '0;
        end
      end
    end
  end

  assign ack_tgl_o = ack_q;
  assign hold_o    = hold_q;
  assign run_o     = run;
  assign flag_o    = flag;
  assign irq_o     = flag && cfg_q.irq_en;

  // R4
  stop_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && cfg_q.mode == MODE_STOP && !(strobe && ld_ctrl_i)) |=> !run);
  // R5
  reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && cfg_q.mode == MODE_RELOAD && !(strobe && ld_cnt_i)) |=> (cnt == 32'd0));
  // R3
  psc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psc_cnt <= psc_q);
  // R9
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (ack_q == $past(req_s)));
endmodule

// File: rtl/tmr_apb_dualclk.sv
module tmr_apb_dualclk
  import tmr_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int PSC_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              tclk,
  input  logic              trstn,
  output logic              irq_bus,
  output logic              irq_tmr
);
  logic             req_tgl, ack_tgl, en, ld_ctrl, ld_cnt, clr, run, flag;
  tmr_cfg_t         cfg;
  logic [PSC_W-1:0] psc;
  logic [31:0]      cnt_val, hold;

  tmr_apb_regs #(.ADDR_W(ADDR_W), .PSC_W(PSC_W), .SYNC_STAGES(SYNC_STAGES)) u_regs (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .req_tgl_o(req_tgl), .cfg_o(cfg), .psc_o(psc), .en_o(en), .cnt_val_o(cnt_val),
    .ld_ctrl_o(ld_ctrl), .ld_cnt_o(ld_cnt), .clr_o(clr),
    .ack_tgl_i(ack_tgl), .hold_i(hold), .run_i(run), .flag_i(flag), .irq_o(irq_bus)
  );

  tmr_count_core #(.PSC_W(PSC_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
    .clk(tclk), .rst_n(trstn), .req_tgl_i(req_tgl), .cfg_i(cfg), .psc_i(psc), .en_i(en),
    .cnt_val_i(cnt_val), .ld_ctrl_i(ld_ctrl), .ld_cnt_i(ld_cnt), .clr_i(clr),
    .ack_tgl_o(ack_tgl), .hold_o(hold), .run_o(run), .flag_o(flag), .irq_o(irq_tmr)
  );
endmodule

// File: tb/test_tmr_apb_dualclk.sv
module test_tmr_apb_dualclk;
  logic pclk = 1'b0, tclk = 1'b0, presetn = 1'b0, trstn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [4:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr, irq_bus, irq_tmr;

  always #5 pclk = ~pclk;
  always #6.5 tclk = ~tclk;

  tmr_apb_dualclk i_tmr_apb_dualclk (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .tclk(tclk), .trstn(trstn), .irq_bus(irq_bus), .irq_tmr(irq_tmr)
  );

  int checks = 0, fails = 0, err_seen = 0, last_waits = 0;
  int tcyc = 0, rise_n = 0, last_rise = 0, prev_rise = 0;
  logic irq_prev = 1'b0;

  always @(negedge tclk) begin
    tcyc++;
    if (irq_tmr && !irq_prev) begin
      prev_rise = last_rise;
      last_rise = tcyc;
      rise_n++;
    end
    irq_prev = irq_tmr;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic check_true(string req, bit cond, logic [31:0] act);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=condition true", req, act);
    end
  endtask

  task automatic apb(input bit wr, input logic [4:0] a, input logic [31:0] d, output logic [31:0] rd);
    int waits = 0;
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    while (!pready) begin
      @(negedge pclk); #1;
      waits++;
    end
    rd = prdata;
    if (pslverr !== 1'b0) err_seen++;
    last_waits = waits;
    @(posedge pclk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    apb(1'b1, a, d, dummy);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    apb(1'b0, a, 32'd0, v);
  endtask

  task automatic wait_rise();
    int n0 = rise_n;
    while (rise_n == n0) @(negedge tclk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge pclk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq_bus", {31'd0, irq_bus}, 32'd0);
    check("R1 irq_tmr", {31'd0, irq_tmr}, 32'd0);
    for (int a = 0; a <= 16; a += 4) begin
      rd(5'(a), v);
      check("R1 register zero", v, 32'd0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(5'h04, 32'h0001_2345); rd(5'h04, v); check("R2 compare", v, 32'h0001_2345);
    wr(5'h08, 32'h0000_0005); rd(5'h08, v); check("R2 prescaler", v, 32'h5);
    wr(5'h00, 32'h0000_000C); rd(5'h00, v); check("R2 control mode/ie", v, 32'hC);
    wr(5'h00, 32'h0); wr(5'h08, 32'h0);
  endtask

  task automatic t_count_rw();
    logic [31:0] v;
    wr(5'h0C, 32'hDEAD_BEEF);
    rd(5'h0C, v);
    check("R9 count load/read", v, 32'hDEAD_BEEF);
    check_true("R9 count wait state", last_waits >= 1, 32'(last_waits));
  endtask

  task automatic t_stop();
    logic [31:0] v;
    wr(5'h00, 32'h0); wr(5'h08, 32'd0); wr(5'h04, 32'd7); wr(5'h0C, 32'd0); wr(5'h10, 32'd1);
    wr(5'h00, 32'h9);
    wait_rise();
    idle(20);
    rd(5'h00, v); check("R4 enable self-cleared", v & 32'h1, 32'd0);
    rd(5'h0C, v); check("R4 count holds compare", v, 32'd7);
    idle(30);
    rd(5'h0C, v); check("R4 count still held", v, 32'd7);
    rd(5'h10, v); check("R7 pending set", v, 32'd1);
  endtask

  task automatic t_reload(int c, int n);
    logic [31:0] v;
    wr(5'h00, 32'h0); wr(5'h0C, 32'd0); wr(5'h08, 32'(n)); wr(5'h04, 32'(c)); wr(5'h10, 32'd1);
    wr(5'h00, 32'hB);
    wait_rise();
    wr(5'h10, 32'd1);
    wait_rise();
    check("R3 R5 match period", 32'(last_rise - prev_rise), 32'(c * (n + 1)));
    for (int i = 0; i < 3; i++) begin
      rd(5'h0C, v);
      check_true("R5 count below compare", v < 32'(c), v);
    end
    wr(5'h00, 32'h0);
  endtask

  task automatic t_free_pause();
    logic [31:0] a, b, v;
    wr(5'h00, 32'h0); wr(5'h08, 32'd0); wr(5'h04, 32'd5); wr(5'h0C, 32'd0); wr(5'h10, 32'd1);
    wr(5'h00, 32'hD);
    wait_rise();
    idle(30);
    rd(5'h0C, a); check_true("R6 runs past compare", a > 32'd5, a);
    idle(10);
    rd(5'h0C, b); check_true("R6 keeps counting", b > a, b);
    rd(5'h10, v); check("R6 pending set", v, 32'd1);
    wr(5'h00, 32'hC);
    rd(5'h0C, a);
    idle(40);
    rd(5'h0C, b); check("R10 frozen while paused", b, a);
    wr(5'h00, 32'hD);
    idle(40);
    rd(5'h0C, b); check_true("R10 resumes from held", b > a && b < a + 200, b);
    wr(5'h00, 32'hC);
  endtask

  task automatic t_mask_clear();
    logic [31:0] v;
    wr(5'h00, 32'h4); idle(10);
    check("R8 irq_bus masked", {31'd0, irq_bus}, 32'd0);
    check("R8 irq_tmr masked", {31'd0, irq_tmr}, 32'd0);
    rd(5'h10, v); check("R8 flag kept while masked", v, 32'd1);
    wr(5'h00, 32'hC); idle(10);
    check("R8 irq_bus unmasked", {31'd0, irq_bus}, 32'd1);
    check("R8 irq_tmr unmasked", {31'd0, irq_tmr}, 32'd1);
    wr(5'h10, 32'd0); idle(10);
    rd(5'h10, v); check("R7 write 0 keeps flag", v, 32'd1);
    wr(5'h10, 32'd1); idle(10);
    rd(5'h10, v); check("R7 write 1 clears flag", v, 32'd0);
    check("R7 irq_bus drops", {31'd0, irq_bus}, 32'd0);
  endtask

  initial begin
    #100000000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge pclk);
    presetn = 1'b1; trstn = 1'b1;
    idle(5);
    t_reset();
    t_regs();
    t_count_rw();
    t_stop();
    t_reload(10, 3);
    t_reload(20, 0);
    t_free_pause();
    t_mask_clear();
    check("R11 pslverr never set", 32'(err_seen), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule